// File: doc/BRIEF.md
# Recordable Replayable Commit-Order Arbiter

This block decides which processor of a chunk-based multiprocessor may commit its current chunk next. Every processor raises a commit request once its chunk is ready. The arbiter answers with a single-cycle acknowledge, and the chunk commits after that. At most one processor commits at a time, so the acknowledges form a total commit order.

The mode input selects how that order is produced.

- **Record mode:** requesters are served round-robin. Each grant pushes the winner's 4-bit identifier out of a log-write port, so the commit interleaving is captured as it happens.
- **Replay mode:** the arbiter reads identifiers from a log-read port. It grants only the processor named by the entry at the head of the stream. Anyone else waits, even when the named processor has not requested yet.
- **Fixed-turn mode:** the turn rotates through the processors in index order and no log is touched.
- **Halt mode:** the fourth code stops all grants.

Log storage, chunk execution and conflict detection live elsewhere.

Top module: `cmt_commit_arbiter`

## Requirements
- R1: After reset no acknowledge, no log-write valid and no log-read ready is asserted, and the bad-entry flag is 0.
- R2: At most one acknowledge bit is high in any cycle. It is high only for a processor whose request bit (bit i = processor i) is high, and it lasts exactly one cycle.
- R3: After a grant, no further grant is issued until the granted processor's request has been seen low. The earliest next grant is in the cycle after that low request is sampled.
- R4: In record mode (mode = 2'b00), the search for a requester starts at the processor after the last one granted in any mode (processor 0 after reset) and wraps past NUM_PROCS-1. Each acknowledge comes with log-write valid in the same cycle, and the log-write data holds the winner's 4-bit unsigned ID.
- R5: In record mode, while log-write ready is low no acknowledge is issued.
- R6: In replay mode (mode = 2'b01), only the processor whose ID is the 4-bit log-read data may be acknowledged. The entry is consumed by asserting log-read ready in the same cycle as that acknowledge, and requests from other processors wait.
- R7: In replay mode, while log-read valid is low no acknowledge is issued.
- R8: In replay mode, a valid log entry with value NUM_PROCS or more is neither consumed nor granted. It sets the bad-entry flag at the next clock edge, and the flag stays set until reset.
- R9: In fixed-turn mode (mode = 2'b10), the turn starts at the processor after the last one granted and advances by one (wrapping to 0) only when the turn holder is granted. A processor is granted only when it holds the turn and requests. No log write or log read takes place.
- R10: In halt mode (mode = 2'b11), no acknowledge and no log handshake is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 record, 01 replay, 10 fixed turn, 11 halt |
| commitReq | input | NUM_PROCS | Commit request, bit i from processor i |
| commitAck | output | NUM_PROCS | One-cycle commit acknowledge, bit i to processor i |
| logWrValid | output | 1 | Log-write entry valid (record mode grant) |
| logWrData | output | ID_W | ID of the granted processor |
| logWrReady | input | 1 | Log sink can accept an entry |
| logRdValid | input | 1 | Log-read entry valid |
| logRdData | input | ID_W | Processor ID at the head of the replay log |
| logRdReady | output | 1 | Head entry consumed this cycle |
| badEntry | output | 1 | Sticky flag: replay log named an ID outside the processor range |

## Verification
The bench builds the block with its defaults: eight processors and 4-bit IDs. With those defaults the log values 8 to 15 can be presented, which is how the out-of-range flag is exercised. Eight processors also make the fixed-turn wrap from 7 back to 0 and the round-robin wrap of the record search reachable in a short run. The vector table passes through record, replay, fixed-turn and halt modes in a single stateful sequence, so the hand-off of the shared rotation pointer between modes is exercised as well.

// File: rtl/cmt_arb_pkg.sv
package cmt_arb_pkg;

  typedef enum logic [1:0] {
    MODE_RECORD = 2'b00,
    MODE_REPLAY = 2'b01,
    MODE_FIXED  = 2'b10,
    MODE_HALT   = 2'b11
  } arbMode_e;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_SEARCH = 2'd1,
    SRC_LOG    = 2'd2,
    SRC_TURN   = 2'd3
  } grantSrc_e;

  // control -> datapath
  typedef struct packed {
    logic      grantEn;
    grantSrc_e src;
    logic      setBad;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic searchHit;
    logic logHit;
    logic logBad;
    logic turnHit;
    logic ownerReq;
  } pathStatus_t;

endpackage

// File: rtl/cmt_arb_path.sv
module cmt_arb_path
  import cmt_arb_pkg::*;
#(
  parameter int NUM_PROCS = 8,
  parameter int ID_W      = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PROCS-1:0] commitReq,
  input  logic                 logRdValid,
  input  logic [ID_W-1:0]      logRdData,
  input  ctrlStrobe_t          strobe,
  output pathStatus_t          status,
  output logic [NUM_PROCS-1:0] grantVec,
  output logic [ID_W-1:0]      grantId,
  output logic                 badFlag
);

  localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_PROCS - 1);

  logic [ID_W-1:0]      rotPtr;
  logic [ID_W-1:0]      ownerId;
  logic [ID_W-1:0]      searchId;
  logic                 searchHit;
  logic [NUM_PROCS-1:0] turnShift;
  logic [NUM_PROCS-1:0] logShift;
  logic [NUM_PROCS-1:0] ownerShift;
  logic                 logInRange;

  // rotating search starting at rotPtr
  always_comb begin
    searchHit = 1'b0;
    searchId  = '0;
    for (int i = 0; i < NUM_PROCS; i++) begin
      int unsigned idx;
      idx = (int'(rotPtr) + i) % NUM_PROCS;
      if (!searchHit && commitReq[idx]) begin
        searchHit = 1'b1;
        searchId  = ID_W'(idx);
      end
    end
  end

  assign turnShift  = commitReq >> rotPtr;
  assign logShift   = commitReq >> logRdData;
  assign ownerShift = commitReq >> ownerId;
  assign logInRange = int'(logRdData) < NUM_PROCS;

  assign status.searchHit = searchHit;
  assign status.turnHit   = turnShift[0];
  assign status.logHit    = logRdValid && logInRange && logShift[0];
  assign status.logBad    = logRdValid && !logInRange;
  assign status.ownerReq  = ownerShift[0];

  always_comb begin
    unique case (strobe.src)
      SRC_SEARCH: grantId = searchId;
      SRC_LOG:    grantId = logRdData;
      SRC_TURN:   grantId = rotPtr;
      default:    grantId = '0;
    endcase
  end

  assign grantVec = strobe.grantEn ? (NUM_PROCS'(1) << grantId) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rotPtr  <= '0;
      ownerId <= '0;
      badFlag <= 1'b0;
    end else begin
      if (strobe.grantEn) begin
        ownerId <= grantId;
        rotPtr  <= (grantId == LAST_ID) ? '0 : grantId + 1'b1;
      end
      if (strobe.setBad) begin
        badFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cmt_arb_ctrl.sv
module cmt_arb_ctrl
  import cmt_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  mode,
  input  pathStatus_t status,
  input  logic        logWrReady,
  output ctrlStrobe_t strobe,
  output logic        logWrValid,
  output logic        logRdReady
);

  arbMode_e modeSel;
  logic     busy;

  assign modeSel = arbMode_e'(mode);

  always_comb begin
    strobe.grantEn = 1'b0;
    strobe.src     = SRC_NONE;
    strobe.setBad  = 1'b0;
    unique case (modeSel)
      MODE_RECORD: begin
        strobe.src     = SRC_SEARCH;
        strobe.grantEn = !busy && status.searchHit && logWrReady;
      end
      MODE_REPLAY: begin
        strobe.src     = SRC_LOG;
        strobe.grantEn = !busy && status.logHit;
        strobe.setBad  = status.logBad;
      end
      MODE_FIXED: begin
        strobe.src     = SRC_TURN;
        strobe.grantEn = !busy && status.turnHit;
      end
      default: begin
        strobe.src     = SRC_NONE;
      end
    endcase
  end

  assign logWrValid = strobe.grantEn && (modeSel == MODE_RECORD);
  assign logRdReady = strobe.grantEn && (modeSel == MODE_REPLAY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (strobe.grantEn) begin
      busy <= 1'b1;
    end else if (busy && !status.ownerReq) begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/cmt_commit_arbiter.sv
module cmt_commit_arbiter
  import cmt_arb_pkg::*;
#(
  parameter int NUM_PROCS = 8,
  parameter int ID_W      = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           mode,
  input  logic [NUM_PROCS-1:0] commitReq,
  output logic [NUM_PROCS-1:0] commitAck,
  output logic                 logWrValid,
  output logic [ID_W-1:0]      logWrData,
  input  logic                 logWrReady,
  input  logic                 logRdValid,
  input  logic [ID_W-1:0]      logRdData,
  output logic                 logRdReady,
  output logic                 badEntry
);

  ctrlStrobe_t strobe;
  pathStatus_t status;
  logic [ID_W-1:0] grantId;

  cmt_arb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .mode       (mode),
    .status     (status),
    .logWrReady (logWrReady),
    .strobe     (strobe),
    .logWrValid (logWrValid),
    .logRdReady (logRdReady)
  );

  cmt_arb_path #(
    .NUM_PROCS (NUM_PROCS),
    .ID_W      (ID_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .commitReq  (commitReq),
    .logRdValid (logRdValid),
    .logRdData  (logRdData),
    .strobe     (strobe),
    .status     (status),
    .grantVec   (commitAck),
    .grantId    (grantId),
    .badFlag    (badEntry)
  );

  assign logWrData = grantId;

endmodule

// File: rtl/cmt_arb_chk.sv
module cmt_arb_chk #(
  parameter int NUM_PROCS = 8,
  parameter int ID_W      = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           mode,
  input logic [NUM_PROCS-1:0] commitReq,
  input logic [NUM_PROCS-1:0] commitAck,
  input logic                 logWrValid,
  input logic [ID_W-1:0]      logWrData,
  input logic                 logWrReady,
  input logic                 logRdValid,
  input logic [ID_W-1:0]      logRdData,
  input logic                 logRdReady,
  input logic                 badEntry
);

  p_one_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(commitAck));

  p_ack_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    (commitAck & ~commitReq) == '0);

  p_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    (commitAck != '0) |=> (commitAck == '0));

  p_record_log_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00 && commitAck != '0) |->
      (logWrValid && commitAck == (NUM_PROCS'(1) << logWrData)));

  p_wr_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00 && !logWrReady) |-> (commitAck == '0));

  p_replay_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    logRdReady |-> (logRdValid && commitAck == (NUM_PROCS'(1) << logRdData)));

  p_replay_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 && !logRdValid) |-> (commitAck == '0 && !logRdReady));

  p_bad_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 && logRdValid && int'(logRdData) >= NUM_PROCS) |=> badEntry);

  p_bad_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    badEntry |=> badEntry);

  p_fixed_nolog_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10) |-> (!logWrValid && !logRdReady));

  p_halt_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11) |-> (commitAck == '0 && !logWrValid && !logRdReady));

endmodule

bind cmt_commit_arbiter cmt_arb_chk #(
  .NUM_PROCS (NUM_PROCS),
  .ID_W      (ID_W)
) u_chk (.*);

// File: tb/tb_cmt_commit_arbiter.sv
module tb_cmt_commit_arbiter;

  localparam int NUM_PROCS = 8;
  localparam int ID_W      = 4;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [1:0]           mode = 2'b00;
  logic [NUM_PROCS-1:0] commitReq = '0;
  logic [NUM_PROCS-1:0] commitAck;
  logic                 logWrValid;
  logic [ID_W-1:0]      logWrData;
  logic                 logWrReady = 1'b0;
  logic                 logRdValid = 1'b0;
  logic [ID_W-1:0]      logRdData = '0;
  logic                 logRdReady;
  logic                 badEntry;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  cmt_commit_arbiter #(.NUM_PROCS(NUM_PROCS), .ID_W(ID_W)) dut (.*);

  typedef struct packed {
    logic [1:0] vMode;
    logic [7:0] vReq;
    logic       vWrRdy;
    logic       vRdVal;
    logic [3:0] vRdData;
    logic [7:0] eAck;
    logic       eWrV;
    logic       eRdR;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 22;
  // state carried across rows; pointer starts at 0 after reset
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h04, 1'b1, 1'b0, 4'd0, 8'h04, 1'b1, 1'b0, 4'd4},  // R4 search from 0 -> 2
    '{2'd0, 8'h04, 1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 4'd3},  // R3 held request
    '{2'd0, 8'h00, 1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 4'd3},  // R3 drop seen
    '{2'd0, 8'h0A, 1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 sink not ready
    '{2'd0, 8'h0A, 1'b1, 1'b0, 4'd0, 8'h08, 1'b1, 1'b0, 4'd4},  // R4 from 3 -> 3
    '{2'd0, 8'h02, 1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 4'd3},
    '{2'd0, 8'h02, 1'b1, 1'b0, 4'd0, 8'h02, 1'b1, 1'b0, 4'd4},  // R4 wrap 4..7,0,1
    '{2'd0, 8'h00, 1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 4'd3},
    '{2'd1, 8'h81, 1'b1, 1'b1, 4'd5, 8'h00, 1'b0, 1'b0, 4'd6},  // R6 named proc absent
    '{2'd1, 8'hA1, 1'b1, 1'b1, 4'd5, 8'h20, 1'b0, 1'b1, 4'd6},  // R6 grant 5 only
    '{2'd1, 8'h81, 1'b1, 1'b1, 4'd7, 8'h00, 1'b0, 1'b0, 4'd3},
    '{2'd1, 8'h81, 1'b1, 1'b0, 4'd7, 8'h00, 1'b0, 1'b0, 4'd7},  // R7 no entry
    '{2'd1, 8'h81, 1'b1, 1'b1, 4'd7, 8'h80, 1'b0, 1'b1, 4'd6},
    '{2'd1, 8'h01, 1'b1, 1'b1, 4'd0, 8'h00, 1'b0, 1'b0, 4'd3},
    '{2'd1, 8'h01, 1'b1, 1'b1, 4'd0, 8'h01, 1'b0, 1'b1, 4'd6},
    '{2'd1, 8'h00, 1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 4'd3},
    '{2'd2, 8'h01, 1'b1, 1'b1, 4'd3, 8'h00, 1'b0, 1'b0, 4'd9},  // R9 turn is 1
    '{2'd2, 8'h03, 1'b1, 1'b1, 4'd3, 8'h02, 1'b0, 1'b0, 4'd9},
    '{2'd2, 8'h01, 1'b1, 1'b1, 4'd3, 8'h00, 1'b0, 1'b0, 4'd3},
    '{2'd2, 8'h05, 1'b1, 1'b1, 4'd3, 8'h04, 1'b0, 1'b0, 4'd9},
    '{2'd2, 8'h00, 1'b1, 1'b1, 4'd3, 8'h00, 1'b0, 1'b0, 4'd3},
    '{2'd3, 8'hFF, 1'b1, 1'b1, 4'd0, 8'h00, 1'b0, 1'b0, 4'd10}  // R10 halt
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    mode = 2'b00; commitReq = '0; logWrReady = 1'b0; logRdValid = 1'b0; logRdData = '0;
    step(); step();
    rstN = 1'b1;
  endtask

  task automatic checkIdle(input string req);
    #1;
    chk(req, 32'(commitAck), 32'h0);
    chk(req, 32'(logWrValid), 32'h0);
    chk(req, 32'(logRdReady), 32'h0);
    chk(req, 32'(badEntry), 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    checkIdle("R1 reset state");

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      string tg;
      tg = $sformatf("R%0d row %0d", VECS[v].tag, v);
      mode       = VECS[v].vMode;
      commitReq  = VECS[v].vReq;
      logWrReady = VECS[v].vWrRdy;
      logRdValid = VECS[v].vRdVal;
      logRdData  = VECS[v].vRdData;
      #1;
      chk(tg, 32'(commitAck), 32'(VECS[v].eAck));
      chk(tg, 32'(logWrValid), 32'(VECS[v].eWrV));
      chk(tg, 32'(logRdReady), 32'(VECS[v].eRdR));
      chk("R2 at most one ack", 32'($countones(commitAck) <= 1), 32'h1);
      if (VECS[v].eWrV) begin
        chk("R4 log data", 32'(commitAck), 32'(NUM_PROCS'(1) << logWrData));
      end
      step();
    end

    // fixed-turn full rotation with wrap
    doReset();
    checkIdle("R1 second reset");
    logWrReady = 1'b1;
    logRdValid = 1'b1;
    for (int k = 0; k < 9; k++) begin
      logic [7:0] bitK;
      bitK = 8'h01 << (k % NUM_PROCS);
      mode = 2'b10;
      commitReq = 8'hFF;
      #1;
      chk($sformatf("R9 turn %0d", k), 32'(commitAck), 32'(bitK));
      chk("R9 no log write", 32'(logWrValid), 32'h0);
      step();
      commitReq = 8'hFF & ~bitK;
      #1;
      chk("R3 busy until drop", 32'(commitAck), 32'h0);
      step();
    end

    // out-of-range replay entry
    mode = 2'b01;
    commitReq = 8'hFF;
    logRdValid = 1'b1;
    logRdData = 4'd9;
    #1;
    chk("R8 bad entry no grant", 32'(commitAck), 32'h0);
    chk("R8 bad entry not consumed", 32'(logRdReady), 32'h0);
    chk("R8 flag before edge", 32'(badEntry), 32'h0);
    step();
    chk("R8 flag set", 32'(badEntry), 32'h1);
    mode = 2'b00;
    logRdValid = 1'b0;
    commitReq = '0;
    step();
    step();
    chk("R8 flag sticky", 32'(badEntry), 32'h1);
    doReset();
    checkIdle("R1 reset clears flag");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule